// File: doc/BRIEF.md
# Hashed Segment Translation Front End

This block is the first stage of a 32-bit MMU that uses a hashed page table. Each request carries an effective address, an access kind (load, store or instruction fetch) and a problem-state bit. The top four address bits choose one of sixteen segment registers, and the selected register sets the protection key. A direct-store segment is resolved in this block, so it needs no table search. Any other segment produces a primary hash, a secondary hash and a compressed match tag. A later stage uses these to probe the page table.

The segment registers are loaded through a single write port. A request is captured at a clock edge, and its result appears one cycle later as a single-cycle valid pulse. The pulse carries a result code, the key, both hashes, the tag, the memory-forced flag and, for a direct-store grant, the real address.

Segment register layout: bit 31 marks direct-store, bit 30 is the supervisor key, bit 29 is the user key, bit 28 is no-execute, and bits 23:0 hold the 24-bit segment ID. On direct-store segments, bits 28:20 form a 9-bit bus unit ID. Access codes on `acc_i` are 00 for load, 01 for store, and 1x for instruction fetch. Result codes on `code_o` are 0 for table lookup required, 1 for direct-store granted, 2 for direct-store refused, and 3 for fetch refused by no-execute. Pages are 4 KB, so the page index is `ea[27:12]`.

Top module: `seg_xlate_front`

## Requirements
- R1: After reset all outputs are 0 and all sixteen segment registers read as 0.
- R2: `vld_o` is 1 exactly in the cycle after a cycle with `req_i` high, and 0 otherwise.
- R3: A request uses segment register `ea_i[31:28]`; a write with `sr_we_i` high stores `sr_wdata_i` into register `sr_idx_i`.
- R4: `key_o` is 1 when (bit 29 is set and `pr_i`=1) or (bit 30 is set and `pr_i`=0), else 0.
- R5: With bit 31 set, no hash is produced (`hash1_o`, `hash2_o`, `tag_o` are 0). The code is 1 when (access is store or key is 0) and (access is load or key is 1); otherwise it is 2.
- R6: On code 1, `raddr_o` equals the request's effective address; on every other code it is 0.
- R7: `mem_forced_o` is 1 only on a direct-store segment whose bits 28:20 equal 9'h07F.
- R8: On a lookup (code 0), `hash1_o` = segment ID XOR zero-extended `ea[27:12]`.
- R9: On a lookup, `hash2_o` is the 24-bit bitwise complement of `hash1_o`.
- R10: On a lookup, `tag_o` (31 bits) = (segment ID << 7) OR `ea[27:22]`.
- R11: A fetch (`acc_i[1]`=1) to a non-direct-store segment with bit 28 set gives code 3, with hashes and tag 0.
- R12: A segment write in the same cycle as a request to that segment does not affect that request; the next request sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_we_i | input | 1 | Segment register write enable |
| sr_idx_i | input | 4 | Segment register write index |
| sr_wdata_i | input | 32 | Segment register write data |
| req_i | input | 1 | Translation request |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| pr_i | input | 1 | Problem state (1 = user) |
| vld_o | output | 1 | Result valid pulse |
| code_o | output | 2 | Result code |
| key_o | output | 1 | Protection key |
| mem_forced_o | output | 1 | Memory-forced direct-store access |
| raddr_o | output | 32 | Real address for a granted direct-store access |
| hash1_o | output | 24 | Primary hash |
| hash2_o | output | 24 | Secondary hash |
| tag_o | output | 31 | Page-table entry match tag |

## Verification
The bench loads every segment register with each of the sixteen combinations of its four control bits. For each combination it issues loads, stores and fetches in both privilege states. This separates the key rule, the store/load-only grant on direct-store segments, and the no-execute refusal, which applies only to fetches on hashed segments.

Segment IDs and address patterns vary per segment, so a wrong segment selection or a mis-sliced page index changes the hashes and the tag. A dedicated bus-ID pattern exercises the memory-forced decode. A write that collides with a request to the same segment shows whether the request captured the old register value.

// File: rtl/xlf_pkg.sv
package xlf_pkg;
  typedef enum logic [1:0] {
    RES_LOOKUP  = 2'd0,
    RES_DS_OK   = 2'd1,
    RES_DS_DENY = 2'd2,
    RES_NOEXEC  = 2'd3
  } res_e;

  localparam int SR_W    = 32;
  localparam int SR_T    = 31;
  localparam int SR_KS   = 30;
  localparam int SR_KP   = 29;
  localparam int SR_NX   = 28;
  localparam int BUID_HI = 28;
  localparam int BUID_LO = 20;
  localparam logic [BUID_HI-BUID_LO:0] BUID_MEMF = 9'h07F;

  localparam logic [1:0] ACC_LOAD  = 2'b00;
  localparam logic [1:0] ACC_STORE = 2'b01;
endpackage

// File: rtl/xlf_seg_regfile.sv
module xlf_seg_regfile #(
  parameter int N_SEG = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(N_SEG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] seg_q [N_SEG];

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        seg_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))  seg_q[g] <= wdata_i;
    end
  end

  // read sees pre-write contents in a colliding cycle
  assign rdata_o = seg_q[ridx_i];
endmodule

// File: rtl/xlf_seg_decode.sv
module xlf_seg_decode
  import xlf_pkg::*;
(
  input  logic [SR_W-1:0] sr_i,
  input  logic            pr_i,
  input  logic [1:0]      acc_i,
  output logic            key_o,
  output logic            direct_o,
  output logic            nx_fetch_o,
  output logic            ds_ok_o,
  output logic            mem_forced_o
);
  logic is_store, is_load, is_fetch;

  assign is_store = (acc_i == ACC_STORE);
  assign is_load  = (acc_i == ACC_LOAD);
  assign is_fetch = acc_i[1];

  assign key_o      = (sr_i[SR_KP] && pr_i) || (sr_i[SR_KS] && !pr_i);
  assign direct_o   = sr_i[SR_T];
  assign nx_fetch_o = is_fetch && sr_i[SR_NX];
  // key=1 admits stores only, key=0 admits loads only
  assign ds_ok_o    = (is_store || !key_o) && (is_load || key_o);
  assign mem_forced_o = sr_i[SR_T] && (sr_i[BUID_HI:BUID_LO] == BUID_MEMF);
endmodule

// File: rtl/xlf_hash_gen.sv
module xlf_hash_gen #(
  parameter int VSID_W    = 24,
  parameter int IDX_W     = 16,
  parameter int TAG_SHIFT = 7,
  parameter int IDX_DROP  = 10,
  localparam int HASH_W   = (VSID_W > IDX_W) ? VSID_W : IDX_W,
  localparam int TAG_W    = VSID_W + TAG_SHIFT
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [IDX_W-1:0]  pidx_i,
  output logic [HASH_W-1:0] hash1_o,
  output logic [HASH_W-1:0] hash2_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign hash1_o = HASH_W'(vsid_i) ^ HASH_W'(pidx_i);
  assign hash2_o = ~hash1_o;
  assign tag_o   = (TAG_W'(vsid_i) << TAG_SHIFT) | TAG_W'(pidx_i >> IDX_DROP);
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front
  import xlf_pkg::*;
#(
  parameter int EA_W      = 32,
  parameter int SEL_W     = 4,
  parameter int PG_SHIFT  = 12,
  parameter int VSID_W    = 24,
  parameter int TAG_SHIFT = 7,
  parameter int IDX_DROP  = 10,
  localparam int N_SEG    = 1 << SEL_W,
  localparam int IDX_W    = EA_W - SEL_W - PG_SHIFT,
  localparam int HASH_W   = (VSID_W > IDX_W) ? VSID_W : IDX_W,
  localparam int TAG_W    = VSID_W + TAG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sr_we_i,
  input  logic [SEL_W-1:0]  sr_idx_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  input  logic              req_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic [1:0]        acc_i,
  input  logic              pr_i,
  output logic              vld_o,
  output logic [1:0]        code_o,
  output logic              key_o,
  output logic              mem_forced_o,
  output logic [EA_W-1:0]   raddr_o,
  output logic [HASH_W-1:0] hash1_o,
  output logic [HASH_W-1:0] hash2_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [SEL_W-1:0]  seg_sel;
  logic [SR_W-1:0]   sr;
  logic [IDX_W-1:0]  pidx;
  logic              key_d, direct_d, nx_fetch_d, ds_ok_d, memf_d;
  logic [HASH_W-1:0] h1_d, h2_d;
  logic [TAG_W-1:0]  tag_d;
  res_e              code_d;

  assign seg_sel = ea_i[EA_W-1 -: SEL_W];
  assign pidx    = ea_i[EA_W-SEL_W-1:PG_SHIFT];

  xlf_seg_regfile #(.N_SEG(N_SEG), .DW(SR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sr_we_i),
    .widx_i  (sr_idx_i),
    .wdata_i (sr_wdata_i),
    .ridx_i  (seg_sel),
    .rdata_o (sr)
  );

  xlf_seg_decode u_dec (
    .sr_i         (sr),
    .pr_i         (pr_i),
    .acc_i        (acc_i),
    .key_o        (key_d),
    .direct_o     (direct_d),
    .nx_fetch_o   (nx_fetch_d),
    .ds_ok_o      (ds_ok_d),
    .mem_forced_o (memf_d)
  );

  xlf_hash_gen #(
    .VSID_W(VSID_W), .IDX_W(IDX_W), .TAG_SHIFT(TAG_SHIFT), .IDX_DROP(IDX_DROP)
  ) u_hash (
    .vsid_i  (sr[VSID_W-1:0]),
    .pidx_i  (pidx),
    .hash1_o (h1_d),
    .hash2_o (h2_d),
    .tag_o   (tag_d)
  );

  always_comb begin
    if (direct_d)        code_d = ds_ok_d ? RES_DS_OK : RES_DS_DENY;
    else if (nx_fetch_d) code_d = RES_NOEXEC;
    else                 code_d = RES_LOOKUP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      code_o       <= '0;
      key_o        <= 1'b0;
      mem_forced_o <= 1'b0;
      raddr_o      <= '0;
      hash1_o      <= '0;
      hash2_o      <= '0;
      tag_o        <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        code_o       <= code_d;
        key_o        <= key_d;
        mem_forced_o <= memf_d;
        raddr_o      <= (code_d == RES_DS_OK) ? ea_i : '0;
        hash1_o      <= (code_d == RES_LOOKUP) ? h1_d : '0;
        hash2_o      <= (code_d == RES_LOOKUP) ? h2_d : '0;
        tag_o        <= (code_d == RES_LOOKUP) ? tag_d : '0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_front_chk.sv
module seg_xlate_front_chk #(
  parameter int EA_W   = 32,
  parameter int HASH_W = 24,
  parameter int TAG_W  = 31
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [EA_W-1:0]   ea_i,
  input logic [1:0]        acc_i,
  input logic              vld_o,
  input logic [1:0]        code_o,
  input logic              mem_forced_o,
  input logic [EA_W-1:0]   raddr_o,
  input logic [HASH_W-1:0] hash1_o,
  input logic [HASH_W-1:0] hash2_o,
  input logic [TAG_W-1:0]  tag_o
);
  AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o); // R2
  AST_VLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o); // R2
  AST_NO_HASH_OFF_LOOKUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && code_o != 2'd0) |-> (hash1_o == '0 && hash2_o == '0 && tag_o == '0)); // R5
  AST_DS_RADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && code_o == 2'd1) |-> raddr_o == $past(ea_i)); // R6
  AST_MEMF_DS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && mem_forced_o) |-> (code_o == 2'd1 || code_o == 2'd2)); // R7
  AST_HASH_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && code_o == 2'd0) |-> hash2_o == ~hash1_o); // R9
  AST_NOEXEC_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && code_o == 2'd3) |-> $past(acc_i[1])); // R11
endmodule

bind seg_xlate_front seg_xlate_front_chk #(
  .EA_W(EA_W), .HASH_W(HASH_W), .TAG_W(TAG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ea_i         (ea_i),
  .acc_i        (acc_i),
  .vld_o        (vld_o),
  .code_o       (code_o),
  .mem_forced_o (mem_forced_o),
  .raddr_o      (raddr_o),
  .hash1_o      (hash1_o),
  .hash2_o      (hash2_o),
  .tag_o        (tag_o)
);

// File: tb/seg_xlate_front_test.sv
module seg_xlate_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_idx = '0;
  logic [31:0] sr_wdata = '0;
  logic        req = 1'b0;
  logic [31:0] ea = '0;
  logic [1:0]  acc = '0;
  logic        pr = 1'b0;
  logic        vld, key, memf;
  logic [1:0]  code;
  logic [31:0] raddr;
  logic [23:0] h1, h2;
  logic [30:0] tag;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] sr_m [16];

  always #10 clk = ~clk;

  seg_xlate_front uut (
    .clk_i(clk), .rst_ni(rst_n), .sr_we_i(sr_we), .sr_idx_i(sr_idx),
    .sr_wdata_i(sr_wdata), .req_i(req), .ea_i(ea), .acc_i(acc), .pr_i(pr),
    .vld_o(vld), .code_o(code), .key_o(key), .mem_forced_o(memf),
    .raddr_o(raddr), .hash1_o(h1), .hash2_o(h2), .tag_o(tag)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    sr_we = 1'b1; sr_idx = idx; sr_wdata = d;
    @(negedge clk);
    sr_we = 1'b0;
    sr_m[idx] = d;
  endtask

  // expected result from a segment value and request fields
  task automatic expect_req(input logic [31:0] s, input logic [31:0] a, input logic [1:0] k,
                            input logic p);
    logic       e_key, e_memf, ok;
    logic [1:0] e_code;
    logic [31:0] e_ra;
    logic [23:0] e_h1, e_h2;
    logic [30:0] e_tag;
    e_key = (s[29] && p) || (s[30] && !p);
    e_memf = 1'b0; e_ra = '0; e_h1 = '0; e_h2 = '0; e_tag = '0;
    if (s[31]) begin
      e_memf = (s[28:20] == 9'h07F);
      ok = (k == 2'b01 || !e_key) && (k == 2'b00 || e_key);
      e_code = ok ? 2'd1 : 2'd2;
      if (ok) e_ra = a;
    end else if (k[1] && s[28]) begin
      e_code = 2'd3;
    end else begin
      e_code = 2'd0;
      e_h1 = s[23:0] ^ {8'h00, a[27:12]};
      e_h2 = ~e_h1;
      e_tag = {s[23:0], 7'b0} | {25'b0, a[27:22]};
    end
    chk(vld === 1'b1, "R2 vld", 64'(vld), 64'd1);
    chk(code === e_code, s[31] ? "R5 code" : (e_code == 2'd3 ? "R11 code" : "R3 code"),
        64'(code), 64'(e_code));
    chk(key === e_key, "R4 key", 64'(key), 64'(e_key));
    chk(raddr === e_ra, "R6 raddr", 64'(raddr), 64'(e_ra));
    chk(memf === e_memf, "R7 memf", 64'(memf), 64'(e_memf));
    chk(h1 === e_h1, "R8 hash1", 64'(h1), 64'(e_h1));
    chk(h2 === e_h2, "R9 hash2", 64'(h2), 64'(e_h2));
    chk(tag === e_tag, "R10 tag", 64'(tag), 64'(e_tag));
  endtask

  task automatic issue(input logic [31:0] a, input logic [1:0] k, input logic p);
    @(negedge clk);
    req = 1'b1; ea = a; acc = k; pr = p;
    @(negedge clk);
    req = 1'b0;
    expect_req(sr_m[a[31:28]], a, k, p);
    @(negedge clk);
    chk(vld === 1'b0, "R2 pulse", 64'(vld), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) sr_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of outputs
    chk(vld === 1'b0 && code === 2'd0 && key === 1'b0 && memf === 1'b0,
        "R1 ctl", {60'b0, vld, code, key}, 64'd0);
    chk(raddr === '0 && h1 === '0 && h2 === '0 && tag === '0,
        "R1 data", 64'(h1), 64'd0);
    // R1: registers read zero after reset
    for (int s = 0; s < 16; s++) issue({s[3:0], 28'h5A5C3F1}, 2'b00, 1'b1);

    // R3/R4/R5/R8/R10/R11 sweep over control bits, privilege, access kind
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic [23:0] v;
        v = 24'(s * 24'h9E3779) ^ 24'(c * 24'h01F3A5);
        wr(s[3:0], {c[3:0], 4'h0, v});
        for (int p = 0; p < 2; p++) begin
          for (int k = 0; k < 3; k++) begin
            logic [27:0] off;
            off = 28'(s * c * 28'h0123457) ^ 28'(k * 28'h0ABCDEF) ^ 28'(p * 28'h8000001);
            issue({s[3:0], off}, k[1:0], p[0]);
          end
        end
      end
    end

    // R7: memory-forced bus ID, and a neighbouring ID that is not
    wr(4'd9, 32'h87F0_0000);
    for (int k = 0; k < 3; k++) issue(32'h9123_4567, k[1:0], 1'b0);
    wr(4'd9, 32'h87E0_0000);
    issue(32'h9123_4567, 2'b00, 1'b0);

    // R12: write colliding with a request to the same segment
    wr(4'd3, 32'h0012_3456);
    @(negedge clk);
    req = 1'b1; ea = 32'h3ABC_D123; acc = 2'b00; pr = 1'b0;
    sr_we = 1'b1; sr_idx = 4'd3; sr_wdata = 32'h00AB_CDEF;
    @(negedge clk);
    req = 1'b0; sr_we = 1'b0;
    chk(h1 === (24'h123456 ^ 24'h00ABCD), "R12 old value", 64'(h1),
        64'(24'h123456 ^ 24'h00ABCD));
    sr_m[3] = 32'h00AB_CDEF;
    issue(32'h3ABC_D123, 2'b00, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule